// File: doc/BRIEF.md
# Transmit Event Queue Index Tracker

This block tracks where the unread entries are in a 32-entry queue of transmit-completion events. It keeps a read index, a write index, a fill level and a sticky overflow flag. It does not store the event records. The owning controller offers one event per completed frame on a valid/ready channel. The host reads a packed status word and writes a one-shot control bit to retire the oldest entry.

The event channel follows valid/ready rules. A beat is accepted in any cycle where `evt_valid` and `evt_ready` are both high. `evt_ready` is high only when the controller is enabled and the queue has room. It is also high when the queue is full but a pop is retiring an entry in the same cycle. The producer is not required to hold `evt_valid` while `evt_ready` is low. An enabled offer made while `evt_ready` is low is counted as a lost event and sets the overflow flag.

A record store beside this block writes the new record at `wr_idx` and reads the oldest record at `entry_addr`. Both outputs come straight from registers, so they are valid from the cycle after each update. Entry addresses start at 0x2000 and step by 8 bytes per entry.

Top module: `txevt_idx_tracker`

## Requirements
- R1: After the asynchronous reset, the fill level, read index, write index and overflow flag are all 0, and `entry_addr` is 0x2000.
- R2: An accepted event (`evt_valid` and `evt_ready` both high) with no pop advances `wr_idx` by one, wrapping 31 to 0, and raises the fill level by one on the next clock.
- R3: A host write (`reg_wr` high) with `reg_wdata` bit 7 set, while the fill level is above 0, advances the read index by one (wrapping 31 to 0) and lowers the fill level by one on the next clock.
- R4: A pop request while the fill level is 0 has no effect: the read index and fill level keep their values.
- R5: A valid pop and an accepted event in the same cycle leave the fill level unchanged and advance both indices. This also holds at fill level 32, where the pop makes `evt_ready` high.
- R6: In `status_word`, bits 13:8 carry the fill level (0 to 32) and bits 4:0 carry the read index. Bit 7, bits 6:5 and bits 31:14 always read 0.
- R7: `entry_addr` equals 0x2000 + 8 × read index; for example, read index 3 gives 0x2018.
- R8: When the queue is full and no pop is pending, `evt_ready` is low. An enabled offer in that state is dropped and sets `overflow`, which stays set until a reset.
- R9: While `ctrl_en` is low, `evt_ready` is low, offered events are neither counted nor flagged, and the fill level and write index hold. Pops still work.
- R10: A synchronous `soft_rst` clears the fill level, both indices and the overflow flag on the next clock.
- R11: `full` is high exactly when the fill level is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of all tracking state |
| ctrl_en | input | 1 | Controller enable; when low, incoming events are refused |
| evt_valid | input | 1 | Completion event offered by the controller |
| evt_ready | output | 1 | Event accepted when high together with `evt_valid` |
| reg_wr | input | 1 | Host write strobe to the status/control word |
| reg_wdata | input | 32 | Host write data; bit 7 requests one pop |
| status_word | output | 32 | Packed status: fill level at 13:8, read index at 4:0 |
| rd_idx | output | 5 | Read index of the oldest entry |
| wr_idx | output | 5 | Slot that the next accepted event occupies |
| entry_addr | output | 16 | Byte address of the entry at the read index |
| full | output | 1 | Fill level equals 32 |
| overflow | output | 1 | Sticky flag: an event was lost while the queue was full |

## Verification
Random stimulus mixes event offers, host pops, the enable input, stray write-data bits and rare soft resets. It runs in long stretches that fill the queue, drain it and wrap both indices past 31. Directed sequences cover the edges. A push-only fill to 32 followed by one more offer separates the dropped-beat path from the accepted path. A simultaneous pop and offer at full and at empty shows the back-pressure exception and the ignored-pop case. Positioning the read index at 3 pins the address arithmetic. Offers while disabled show that the enable gates counting without freezing pops.

// File: rtl/txevt_pkg.sv
package txevt_pkg;
  localparam int unsigned POP_BIT  = 7;
  localparam int unsigned FILL_LSB = 8;

  typedef enum logic [1:0] {
    LV_HOLD = 2'd0,
    LV_INC  = 2'd1,
    LV_DEC  = 2'd2
  } lvl_op_e;
endpackage

// File: rtl/txevt_ptr.sv
module txevt_ptr #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (clr)
      idx_q <= '0;
    else if (adv)
      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx = idx_q;
endmodule

// File: rtl/txevt_level.sv
module txevt_level
  import txevt_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);

  logic [LVL_W-1:0] lvl_q;
  lvl_op_e          op;

  always_comb begin
    unique case ({push, pop})
      2'b10:   op = LV_INC;
      2'b01:   op = LV_DEC;
      default: op = LV_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lvl_q <= '0;
    else if (clr)
      lvl_q <= '0;
    else begin
      unique case (op)
        LV_INC:  lvl_q <= lvl_q + 1'b1;
        LV_DEC:  lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assign level = lvl_q;
  assign full  = (lvl_q == TOP);
  assign empty = (lvl_q == '0);
endmodule

// File: rtl/txevt_status.sv
module txevt_status
  import txevt_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned LVL_W  = 6,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h2000,
  parameter int unsigned STRIDE = 8
) (
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [LVL_W-1:0]  level,
  output logic [31:0]       status_word,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam int unsigned SHIFT = $clog2(STRIDE);

  always_comb begin
    status_word = '0;
    status_word[FILL_LSB +: LVL_W] = level;
    status_word[IDX_W-1:0]         = rd_idx;
  end

  generate
    if ((1 << SHIFT) == STRIDE) begin : g_pow2
      assign entry_addr = BASE + (ADDR_W'(rd_idx) << SHIFT);
    end else begin : g_mul
      assign entry_addr = BASE + ADDR_W'(rd_idx) * ADDR_W'(STRIDE);
    end
  endgenerate
endmodule

// File: rtl/txevt_idx_tracker.sv
module txevt_idx_tracker
  import txevt_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h2000,
  parameter int unsigned STRIDE = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              ctrl_en,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       status_word,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              full,
  output logic              overflow
);
  logic             pop_req, pop_go, push_go, drop;
  logic             empty;
  logic [LVL_W-1:0] level;
  logic             ovf_q;

  assign pop_req   = reg_wr & reg_wdata[POP_BIT];
  assign pop_go    = pop_req & ~empty;
  assign evt_ready = ctrl_en & (~full | pop_go);
  assign push_go   = evt_valid & evt_ready;
  assign drop      = ctrl_en & evt_valid & ~evt_ready;

  txevt_ptr #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .adv(pop_go), .idx(rd_idx)
  );

  txevt_ptr #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .adv(push_go), .idx(wr_idx)
  );

  txevt_level #(.DEPTH(DEPTH)) u_lvl (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .push(push_go), .pop(pop_go),
    .level(level), .full(full), .empty(empty)
  );

  txevt_status #(
    .IDX_W(IDX_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
  ) u_stat (
    .rd_idx(rd_idx), .level(level),
    .status_word(status_word), .entry_addr(entry_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovf_q <= 1'b0;
    else if (soft_rst)
      ovf_q <= 1'b0;
    else if (drop)
      ovf_q <= 1'b1;
  end

  assign overflow = ovf_q;
endmodule

// File: rtl/txevt_idx_tracker_chk.sv
module txevt_idx_tracker_chk #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned LVL_W = 6,
  parameter int unsigned DEPTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             ctrl_en,
  input logic             evt_valid,
  input logic             evt_ready,
  input logic             reg_wr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      status_word,
  input logic [IDX_W-1:0] rd_idx,
  input logic [IDX_W-1:0] wr_idx,
  input logic             full,
  input logic             overflow
);
  logic [LVL_W-1:0] fill;
  logic             pop_req;
  assign fill    = status_word[8 +: LVL_W];
  assign pop_req = reg_wr & reg_wdata[7];

  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= LVL_W'(DEPTH));

  assert_idx_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (IDX_W'(fill) == IDX_W'(wr_idx - rd_idx)));

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && fill == '0 && !soft_rst) |=> $stable(rd_idx));

  assert_sticky_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !soft_rst) |=> overflow);

  assert_full_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_req) |-> !evt_ready);

  assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !soft_rst) |=> $stable(wr_idx));

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (fill == '0 && !overflow && rd_idx == '0));

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[31:14] == '0 && status_word[7:5] == '0);

  assert_full_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    full == (fill == LVL_W'(DEPTH)));
endmodule

bind txevt_idx_tracker txevt_idx_tracker_chk #(
  .IDX_W(IDX_W), .LVL_W(LVL_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctrl_en(ctrl_en),
  .evt_valid(evt_valid), .evt_ready(evt_ready), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .status_word(status_word), .rd_idx(rd_idx),
  .wr_idx(wr_idx), .full(full), .overflow(overflow)
);

// File: tb/sim_txevt_idx_tracker.sv
module sim_txevt_idx_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        ctrl_en = 1'b0;
  logic        evt_valid = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        evt_ready, full, overflow;
  logic [31:0] status_word;
  logic [4:0]  rd_idx, wr_idx;
  logic [15:0] entry_addr;

  int checks = 0, fails = 0, cycles = 0;
  int m_fill = 0, m_rd = 0, m_wr = 0;
  bit m_ovf = 0;

  always #2.5 clk = ~clk;

  txevt_idx_tracker u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctrl_en(ctrl_en),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .status_word(status_word), .rd_idx(rd_idx),
    .wr_idx(wr_idx), .entry_addr(entry_addr), .full(full), .overflow(overflow)
  );

  function automatic logic [31:0] exp_status(int f, int r);
    logic [31:0] s = '0;
    s[13:8] = 6'(f);
    s[4:0]  = 5'(r);
    return s;
  endfunction

  function automatic logic [15:0] exp_addr(int r);
    return 16'h2000 + 16'(r * 8);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_state();
    chk("R2 fill", status_word[13:8], m_fill);
    chk("R3 rd_idx", rd_idx, m_rd);
    chk("R2 wr_idx", wr_idx, m_wr);
    chk("R6 status", status_word, exp_status(m_fill, m_rd));
    chk("R7 addr", entry_addr, exp_addr(m_rd));
    chk("R11 full", full, m_fill == 32);
    chk("R8 overflow", overflow, m_ovf);
  endtask

  // Drive one cycle at a negedge, check ready, update model, advance to next negedge.
  task automatic step(bit v, bit pop, bit en, bit srst, logic [31:0] junk = '0);
    bit pgo, rdy;
    evt_valid = v;
    ctrl_en   = en;
    soft_rst  = srst;
    reg_wr    = pop | junk[0];
    reg_wdata = junk & ~32'h80;
    if (pop) reg_wdata[7] = 1'b1;
    #1;
    pgo = reg_wr && reg_wdata[7] && m_fill > 0;
    rdy = en && (m_fill < 32 || pgo);
    chk("R8 evt_ready", evt_ready, rdy);
    if (srst) begin
      m_fill = 0; m_rd = 0; m_wr = 0; m_ovf = 0;
    end else begin
      if (pgo) m_rd = (m_rd + 1) % 32;
      if (v && rdy) m_wr = (m_wr + 1) % 32;
      m_fill = m_fill + ((v && rdy) ? 1 : 0) - (pgo ? 1 : 0);
      if (en && v && !rdy) m_ovf = 1;
    end
    @(negedge clk);
    check_state();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 fill", status_word[13:8], 0);
    chk("R1 rd_idx", rd_idx, 0);
    chk("R1 wr_idx", wr_idx, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 addr", entry_addr, 16'h2000);
    rst_n = 1'b1;
    @(negedge clk);
    check_state();

    // R2, R11: fill to 32
    repeat (32) step(1, 0, 1, 0);
    chk("R11 full at 32", full, 1);
    // R8: offer while full without pop is dropped
    step(1, 0, 1, 0);
    chk("R8 drop keeps fill", status_word[13:8], 32);
    chk("R8 overflow set", overflow, 1);
    // R5: pop and offer at full
    step(1, 1, 1, 0);
    chk("R5 fill at full", status_word[13:8], 32);
    chk("R5 rd_idx moved", rd_idx, 1);
    // R3: drain, wrap read index
    repeat (32) step(0, 1, 1, 0);
    chk("R3 drained", status_word[13:8], 0);
    chk("R3 rd wrap", rd_idx, 1);
    // R4: pop while empty
    step(0, 1, 1, 0);
    chk("R4 rd hold", rd_idx, 1);
    chk("R4 fill hold", status_word[13:8], 0);
    // R5: pop and offer at empty -> pop ignored
    step(1, 1, 1, 0);
    chk("R5 empty pop+push", status_word[13:8], 1);
    // R10: soft reset
    step(0, 0, 1, 1);
    chk("R10 fill", status_word[13:8], 0);
    chk("R10 overflow", overflow, 0);
    // R7: read index 3 -> 0x2018
    repeat (4) step(1, 0, 1, 0);
    repeat (3) step(0, 1, 1, 0);
    chk("R7 addr idx3", entry_addr, 16'h2018);
    // R9: disabled offers ignored, pop still works
    step(1, 0, 0, 0);
    chk("R9 fill hold", status_word[13:8], 1);
    chk("R9 no overflow", overflow, 0);
    step(1, 1, 0, 0);
    chk("R9 pop while off", status_word[13:8], 0);
    // R6: write with bit7 clear and stray bits set does not pop
    step(1, 0, 1, 0, 32'hFFFF_FF7F);
    chk("R6 no pop from other bits", status_word[13:8], 1);
    chk("R6 bit7 reads 0", status_word[7], 0);

    // Random phases
    for (int i = 0; i < 6000; i++) begin
      int phase = (i / 300) % 3;
      int pv = (phase == 0) ? 85 : (phase == 1) ? 25 : 55;
      int pp = (phase == 0) ? 20 : (phase == 1) ? 80 : 50;
      bit v   = ($urandom % 100) < pv;
      bit p   = ($urandom % 100) < pp;
      bit en  = ($urandom % 100) < 90;
      bit sr  = ($urandom % 1000) < 2;
      logic [31:0] j = (($urandom % 4) == 0) ? $urandom : 32'h0;
      step(v, p, en, sr, j);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule